// File: doc/BRIEF.md
# Five-State Snooping Coherence Line Controller

This block keeps the coherence state of every line in a small, directly indexed cache that shares memory with other caches over a snooping bus. Each entry holds a tag and one of five states: invalid, shared, exclusive, owned or modified. Local processor reads and writes are looked up against the entry their address selects. A hit that needs no bus traffic completes in the same cycle. Any other access issues one bus request and waits for a grant.

Requests seen on the bus from other caches are snooped every cycle. A snoop can downgrade or drop the matching line. When this cache holds the only current copy, the snoop raises a flag so that this cache, and not memory, provides the data. When a miss displaces a line whose data memory does not have, the block raises a writeback request that carries the victim's address.

Data arrays, bus arbitration and any replacement policy beyond the single indexed victim belong to neighbouring blocks.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is invalid: no snoop reports a hit, the first local access to any address misses, and cpu_done, wb_req and bus_req_valid are low.
- R2: A read miss raises bus_req_valid from the next cycle with bus_req_cmd 2'b01 (read) and the request address. In the cycle bus_grant is high, cpu_done is high. The line then becomes exclusive if bus_shared_in was low in that cycle, and shared if it was high.
- R3: A write miss requests with bus_req_cmd 2'b10 (read-for-ownership), and the line becomes modified on grant.
- R4: A write to a shared or owned line requests with bus_req_cmd 2'b11 (invalidate) and becomes modified on grant. A write to an exclusive line becomes modified with cpu_done in the same cycle and no bus request. A write to a modified line also completes in the same cycle.
- R5: A read hit in any valid state raises cpu_done in the same cycle, issues no bus request and leaves the state unchanged.
- R6: A snoop with snoop_cmd 2'b01 (read) that hits raises snoop_shared. It raises snoop_supply and leaves the line owned when the line was modified or owned. It moves exclusive to shared, and leaves shared as it is, without supply.
- R7: A snoop with snoop_cmd 2'b10 (read-for-ownership) that hits invalidates the line. It raises snoop_supply only if the line was modified or owned.
- R8: A snoop with snoop_cmd 2'b11 (invalidate) that hits invalidates the line and never raises snoop_supply.
- R9: A snoop whose tag differs from the indexed line, that finds the line invalid, or that carries snoop_cmd 2'b00 raises neither output and changes no state.
- R10: A miss on an entry that holds a different valid tag raises wb_req in the cycle the access is taken, with wb_addr set to the victim's tag and index, when the victim is modified or owned. No writeback is raised when the victim is exclusive or shared. The victim becomes invalid either way.
- R11: A snoop takes priority over a local access: in a cycle with snoop_valid high, no local access is taken, and cpu_done and wb_req stay low.
- R12: A pending invalidate request changes to read-for-ownership from the next cycle on when a read-for-ownership or invalidate snoop to the same address arrives while it waits.
- R13: bus_req_valid, bus_req_addr and the command stay asserted until bus_grant, except for the change in R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req_valid | input | 1 | Local access present; held until cpu_done |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address, index in the low bits, tag above |
| cpu_done | output | 1 | Local access completes this cycle |
| wb_req | output | 1 | Dirty victim must be written back |
| wb_addr | output | ADDR_W | Victim line address |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 2 | 01 read, 10 read-for-ownership, 11 invalidate |
| bus_req_addr | output | ADDR_W | Requested line address |
| bus_grant | input | 1 | Pending request performed this cycle; never high together with snoop_valid |
| bus_shared_in | input | 1 | Another cache holds the line (read grants) |
| snoop_valid | input | 1 | Request from another cache on the bus |
| snoop_cmd | input | 2 | Same encoding as bus_req_cmd, 00 = none |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_supply | output | 1 | This cache provides the data, not memory |
| snoop_shared | output | 1 | This cache holds the snooped line |

ADDR_W = TAG_W + log2(NUM_LINES).

## Verification
The bench builds the block with NUM_LINES = 4 and TAG_W = 2, so a 4-bit address space has four tags competing for each entry. Random accesses then often displace lines in every one of the five states. Random snoops often hit lines that local accesses have just brought in. The small space also makes it likely that a snoop lands on the same address as a waiting upgrade, and that a snoop coincides with a held-off local access.

// File: rtl/moesi_pkg.sv
// Package: shared types and snoop transition helpers for the line controller.
// Assumes a five-state encoding where 0 is invalid; bus and snoop commands
// share one 2-bit encoding.
package moesi_pkg;

    typedef enum logic [2:0] {
        LN_INV = 3'd0,
        LN_SHR = 3'd1,
        LN_EXC = 3'd2,
        LN_OWN = 3'd3,
        LN_MOD = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_READ = 2'd1,
        BC_RFO  = 2'd2,
        BC_INV  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } req_ph_e;

    // State a hit line takes after a snoop of the given kind.
    function automatic line_st_e snoop_next(input line_st_e cur, input logic [1:0] cmd);
        line_st_e nxt;
        nxt = cur;
        case (cmd)
            BC_READ: begin
                if (cur == LN_MOD) nxt = LN_OWN;
                else if (cur == LN_EXC) nxt = LN_SHR;
            end
            BC_RFO, BC_INV: nxt = LN_INV;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

    // True when this cache holds the only current data and the snoop wants it.
    function automatic logic snoop_gives_data(input line_st_e cur, input logic [1:0] cmd);
        return ((cmd == BC_READ) || (cmd == BC_RFO)) &&
               ((cur == LN_MOD) || (cur == LN_OWN));
    endfunction

    // True when evicting a line in this state needs a writeback.
    function automatic logic is_dirty(input line_st_e cur);
        return (cur == LN_MOD) || (cur == LN_OWN);
    endfunction

endpackage

// File: rtl/moesi_line_store.sv
// Line store: per-entry tag and coherence state registers.
// Two combinational read ports (local side, snoop side) and one write port.
// Assumes the caller resolves write conflicts before the write port.
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 4,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ST_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    output line_st_e         rd_a_state,
    output logic [TAG_W-1:0] rd_a_tag,
    input  logic [IDX_W-1:0] rd_b_idx,
    output line_st_e         rd_b_state,
    output logic [TAG_W-1:0] rd_b_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_st_e         wr_state,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [NUM_LINES*ST_W-1:0]  st_flat;
    logic [NUM_LINES*TAG_W-1:0] tag_flat;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_entry
        line_st_e         st_q;
        logic [TAG_W-1:0] tag_q;
        logic             hit_wr;

        assign hit_wr = wr_en && (wr_idx == IDX_W'(g));

        // Entry register: clears to invalid, loads on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= LN_INV;
                tag_q <= '0;
            end else if (hit_wr) begin
                st_q  <= wr_state;
                tag_q <= wr_tag;
            end
        end

        assign st_flat[g*ST_W +: ST_W]    = st_q;
        assign tag_flat[g*TAG_W +: TAG_W] = tag_q;
    end

    // Read ports: select the indexed entry for each side.
    always_comb begin
        rd_a_state = line_st_e'(st_flat[rd_a_idx*ST_W +: ST_W]);
        rd_a_tag   = tag_flat[rd_a_idx*TAG_W +: TAG_W];
        rd_b_state = line_st_e'(st_flat[rd_b_idx*ST_W +: ST_W]);
        rd_b_tag   = tag_flat[rd_b_idx*TAG_W +: TAG_W];
    end

endmodule

// File: rtl/moesi_snoop_unit.sv
// Snoop unit: decides the response to a snooped bus request for one line.
// Purely combinational; assumes the line read matches the snoop index.
module moesi_snoop_unit
    import moesi_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             snoop_valid,
    input  logic [1:0]       snoop_cmd,
    input  logic [TAG_W-1:0] snoop_tag,
    input  line_st_e         line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output logic             supply,
    output line_st_e         next_state
);

    // Hit detection and response for the indexed line.
    always_comb begin
        hit        = snoop_valid && (snoop_cmd != BC_NONE) &&
                     (line_state != LN_INV) && (line_tag == snoop_tag);
        supply     = hit && snoop_gives_data(line_state, snoop_cmd);
        next_state = hit ? snoop_next(line_state, snoop_cmd) : line_state;
    end

endmodule

// File: rtl/moesi_req_fsm.sv
// Request sequencer: serves local reads and writes against the indexed line.
// Hits needing no bus traffic finish in the accept cycle; others raise one
// bus request and wait for a grant. Assumes cpu_req_* is held until cpu_done
// and that bus_grant never coincides with snoop_valid.
module moesi_req_fsm
    import moesi_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 3,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  line_st_e          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    output logic              cpu_done,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic              lw_en,
    output logic [IDX_W-1:0]  lw_idx,
    output line_st_e          lw_state,
    output logic [TAG_W-1:0]  lw_tag
);

    req_ph_e           ph_q;
    bus_cmd_e          pend_cmd_q;
    logic [ADDR_W-1:0] pend_addr_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              accept;
    logic              tag_hit;
    logic              go_bus;
    bus_cmd_e          new_cmd;
    logic              downgrade;

    assign req_idx = cpu_req_addr[IDX_W-1:0];
    assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];

    // Lookup and accept decision for a local access.
    always_comb begin
        tag_hit = (line_state != LN_INV) && (line_tag == req_tag);
        accept  = (ph_q == PH_IDLE) && cpu_req_valid && !snoop_valid;
    end

    // Per-cycle outputs and the local write into the line store.
    always_comb begin
        cpu_done = 1'b0;
        wb_req   = 1'b0;
        wb_addr  = {line_tag, req_idx};
        go_bus   = 1'b0;
        new_cmd  = BC_READ;
        lw_en    = 1'b0;
        lw_idx   = req_idx;
        lw_state = LN_INV;
        lw_tag   = req_tag;
        if (accept) begin
            if (!cpu_req_write && tag_hit) begin
                cpu_done = 1'b1;
            end else if (cpu_req_write && tag_hit &&
                         (line_state == LN_MOD || line_state == LN_EXC)) begin
                cpu_done = 1'b1;
                if (line_state == LN_EXC) begin
                    lw_en    = 1'b1;
                    lw_state = LN_MOD;
                end
            end else begin
                go_bus = 1'b1;
                if (!cpu_req_write)  new_cmd = BC_READ;
                else if (tag_hit)    new_cmd = BC_INV;
                else                 new_cmd = BC_RFO;
                if (line_state != LN_INV && !tag_hit) begin
                    lw_en    = 1'b1;
                    lw_state = LN_INV;
                    lw_tag   = line_tag;
                    wb_req   = is_dirty(line_state);
                end
            end
        end else if (ph_q == PH_WAIT && bus_grant) begin
            cpu_done = 1'b1;
            lw_en    = 1'b1;
            lw_idx   = pend_addr_q[IDX_W-1:0];
            lw_tag   = pend_addr_q[ADDR_W-1:IDX_W];
            if (pend_cmd_q == BC_READ) lw_state = bus_shared_in ? LN_SHR : LN_EXC;
            else                       lw_state = LN_MOD;
        end
    end

    // Detect a snoop that kills the copy a pending upgrade relies on.
    always_comb begin
        downgrade = (ph_q == PH_WAIT) && (pend_cmd_q == BC_INV) && snoop_valid &&
                    ((snoop_cmd == BC_RFO) || (snoop_cmd == BC_INV)) &&
                    (snoop_addr == pend_addr_q);
    end

    // Phase and pending request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q        <= PH_IDLE;
            pend_cmd_q  <= BC_NONE;
            pend_addr_q <= '0;
        end else if (ph_q == PH_IDLE) begin
            if (go_bus) begin
                ph_q        <= PH_WAIT;
                pend_cmd_q  <= new_cmd;
                pend_addr_q <= cpu_req_addr;
            end
        end else begin
            if (bus_grant) begin
                ph_q       <= PH_IDLE;
                pend_cmd_q <= BC_NONE;
            end else if (downgrade) begin
                pend_cmd_q <= BC_RFO;
            end
        end
    end

    // Bus request outputs come straight from the pending registers.
    always_comb begin
        bus_req_valid = (ph_q == PH_WAIT);
        bus_req_cmd   = pend_cmd_q;
        bus_req_addr  = pend_addr_q;
    end

endmodule

// File: rtl/moesi_line_ctrl.sv
// Top: five-state coherence controller for a directly indexed cache.
// Joins the line store, snoop unit and request sequencer; a snoop update
// wins the single write port (the sequencer never writes in a snoop cycle).
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 4,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ADDR_W   = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_done,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              bus_shared_in,
    input  logic              snoop_valid,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_supply,
    output logic              snoop_shared
);

    line_st_e         a_state, b_state, snp_next, lw_state, wr_state;
    logic [TAG_W-1:0] a_tag, b_tag, lw_tag, wr_tag;
    logic [IDX_W-1:0] lw_idx, wr_idx;
    logic             lw_en, snp_hit, wr_en;

    moesi_line_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (cpu_req_addr[IDX_W-1:0]),
        .rd_a_state (a_state),
        .rd_a_tag   (a_tag),
        .rd_b_idx   (snoop_addr[IDX_W-1:0]),
        .rd_b_state (b_state),
        .rd_b_tag   (b_tag),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_state   (wr_state),
        .wr_tag     (wr_tag)
    );

    moesi_snoop_unit #(
        .TAG_W (TAG_W)
    ) snoop_i (
        .snoop_valid (snoop_valid),
        .snoop_cmd   (snoop_cmd),
        .snoop_tag   (snoop_addr[ADDR_W-1:IDX_W]),
        .line_state  (b_state),
        .line_tag    (b_tag),
        .hit         (snp_hit),
        .supply      (snoop_supply),
        .next_state  (snp_next)
    );

    moesi_req_fsm #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_req_valid (cpu_req_valid),
        .cpu_req_write (cpu_req_write),
        .cpu_req_addr  (cpu_req_addr),
        .line_state    (a_state),
        .line_tag      (a_tag),
        .snoop_valid   (snoop_valid),
        .snoop_cmd     (snoop_cmd),
        .snoop_addr    (snoop_addr),
        .bus_grant     (bus_grant),
        .bus_shared_in (bus_shared_in),
        .cpu_done      (cpu_done),
        .wb_req        (wb_req),
        .wb_addr       (wb_addr),
        .bus_req_valid (bus_req_valid),
        .bus_req_cmd   (bus_req_cmd),
        .bus_req_addr  (bus_req_addr),
        .lw_en         (lw_en),
        .lw_idx        (lw_idx),
        .lw_state      (lw_state),
        .lw_tag        (lw_tag)
    );

    // Write-port selection: snoop update first, local update otherwise.
    always_comb begin
        wr_en    = snp_hit || lw_en;
        wr_idx   = snp_hit ? snoop_addr[IDX_W-1:0] : lw_idx;
        wr_state = snp_hit ? snp_next : lw_state;
        wr_tag   = snp_hit ? b_tag : lw_tag;
    end

    assign snoop_shared = snp_hit;

endmodule

// File: rtl/moesi_line_ctrl_chk.sv
// Checker: port-level protocol properties of the line controller.
// Attached to every instance of the top module through the bind below.
module moesi_line_ctrl_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_done,
    input logic              wb_req,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_grant,
    input logic              snoop_valid,
    input logic [1:0]        snoop_cmd,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              snoop_supply,
    input logic              snoop_shared
);

    assert_env_no_grant_in_snoop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_valid && bus_grant));

    assert_grant_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_grant |-> cpu_done);

    assert_taken_miss_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && !bus_req_valid && !snoop_valid && !cpu_done |=> bus_req_valid);

    assert_hit_no_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !bus_req_valid);

    assert_supply_is_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_supply |-> snoop_valid && snoop_shared);

    assert_inv_no_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && snoop_cmd == 2'b11 |-> !snoop_supply);

    assert_none_no_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid || snoop_cmd == 2'b00 |-> !snoop_shared && !snoop_supply);

    assert_wb_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !cpu_done && !bus_req_valid && cpu_req_valid);

    assert_snoop_holds_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid |-> !cpu_done && !wb_req);

    assert_upgrade_demoted_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_req_cmd == 2'b11 && snoop_valid &&
        (snoop_cmd == 2'b10 || snoop_cmd == 2'b11) && snoop_addr == bus_req_addr
        |=> bus_req_valid && bus_req_cmd == 2'b10);

    assert_request_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_grant |=> bus_req_valid && $stable(bus_req_addr));

    assert_cmd_nonzero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> bus_req_cmd != 2'b00);

endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_done      (cpu_done),
    .wb_req        (wb_req),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (bus_req_cmd),
    .bus_req_addr  (bus_req_addr),
    .bus_grant     (bus_grant),
    .snoop_valid   (snoop_valid),
    .snoop_cmd     (snoop_cmd),
    .snoop_addr    (snoop_addr),
    .snoop_supply  (snoop_supply),
    .snoop_shared  (snoop_shared)
);

// File: tb/moesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, checked against a
// behavioural line-state model kept in the bench.
module moesi_line_ctrl_tb_top;

    localparam int NL = 4;
    localparam int TW = 2;
    localparam int IW = 2;
    localparam int AW = TW + IW;
    localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic          cpu_done, wb_req, bus_req_valid, snoop_supply, snoop_shared;
    logic [AW-1:0] wb_addr, bus_req_addr;
    logic [1:0]    bus_req_cmd;
    logic          bus_grant = 1'b0, bus_shared_in = 1'b0;
    logic          snoop_valid = 1'b0;
    logic [1:0]    snoop_cmd = '0;
    logic [AW-1:0] snoop_addr = '0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    int m_st [NL];
    int m_tag [NL];

    always #4 clk = ~clk;

    moesi_line_ctrl #(.NUM_LINES(NL), .TAG_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_done(cpu_done),
        .wb_req(wb_req), .wb_addr(wb_addr),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_grant(bus_grant),
        .bus_shared_in(bus_shared_in), .snoop_valid(snoop_valid),
        .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
        .snoop_supply(snoop_supply), .snoop_shared(snoop_shared)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int snp_next(input int s, input int cmd);
        if (cmd == 1) return (s == SM) ? SO : (s == SE) ? SS : s;
        if (cmd == 2 || cmd == 3) return SI;
        return s;
    endfunction

    function automatic int snp_gives(input int s, input int cmd);
        return ((cmd == 1 || cmd == 2) && (s == SM || s == SO)) ? 1 : 0;
    endfunction

    // Compare snoop outputs with the model while a snoop is driven, then update.
    task automatic eval_snoop(input int cmd, input int addr);
        int idx, tg, hit;
        string tagr;
        idx = addr % NL;
        tg  = addr / NL;
        hit = (cmd != 0 && m_st[idx] != SI && m_tag[idx] == tg) ? 1 : 0;
        tagr = !hit ? "R9" : (cmd == 1) ? "R6" : (cmd == 2) ? "R7" : "R8";
        check({tagr, " snoop_shared"}, int'(snoop_shared), hit);
        check({tagr, " snoop_supply"}, int'(snoop_supply), hit ? snp_gives(m_st[idx], cmd) : 0);
        if (hit) m_st[idx] = snp_next(m_st[idx], cmd);
    endtask

    task automatic do_snoop(input int cmd, input int addr);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_cmd   = 2'(cmd);
        snoop_addr  = AW'(addr);
        #1 eval_snoop(cmd, addr);
        @(posedge clk);
        #1 snoop_valid = 1'b0;
    endtask

    task automatic do_cpu(input bit wr, input int addr, input int delay, input bit shr,
                          input bit snp_wait, input int s_cmd, input int s_addr,
                          input bit holdoff, input int h_cmd, input int h_addr);
        int idx, tg, st, hit, exp_cmd, exp_wb;
        idx = addr % NL;
        tg  = addr / NL;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = AW'(addr);
        if (holdoff) begin
            snoop_valid = 1'b1;
            snoop_cmd   = 2'(h_cmd);
            snoop_addr  = AW'(h_addr);
            #1;
            check("R11 cpu_done held off", int'(cpu_done), 0);
            check("R11 wb_req held off", int'(wb_req), 0);
            eval_snoop(h_cmd, h_addr);
            @(posedge clk);
            #1 snoop_valid = 1'b0;
            @(negedge clk);
        end
        #1;
        st  = m_st[idx];
        hit = (st != SI && m_tag[idx] == tg) ? 1 : 0;
        if (!wr && hit) begin
            check("R5 read hit done", int'(cpu_done), 1);
            check("R5 read hit no wb", int'(wb_req), 0);
        end else if (wr && hit && (st == SM || st == SE)) begin
            check("R4 silent write done", int'(cpu_done), 1);
            m_st[idx] = SM;
        end else begin
            check("R2 no done at issue", int'(cpu_done), 0);
            exp_wb = (st != SI && !hit && (st == SM || st == SO)) ? 1 : 0;
            check("R10 wb_req", int'(wb_req), exp_wb);
            if (exp_wb) check("R10 wb_addr", int'(wb_addr), m_tag[idx] * NL + idx);
            if (st != SI && !hit) m_st[idx] = SI;
            exp_cmd = !wr ? 1 : hit ? 3 : 2;
            for (int cyc = 0; cyc <= delay; cyc++) begin
                @(posedge clk);
                @(negedge clk);
                bus_grant     = (cyc == delay);
                bus_shared_in = shr;
                if (cyc == 0 && snp_wait && delay > 0) begin
                    snoop_valid = 1'b1;
                    snoop_cmd   = 2'(s_cmd);
                    snoop_addr  = AW'(s_addr);
                end
                #1;
                check("R13 bus_req_valid", int'(bus_req_valid), 1);
                check(exp_cmd == 1 ? "R2 cmd" : exp_cmd == 2 ? "R3 cmd" : "R4 cmd",
                      int'(bus_req_cmd), exp_cmd);
                check("R13 bus_req_addr", int'(bus_req_addr), addr);
                check("R2 cpu_done on grant", int'(cpu_done), (cyc == delay) ? 1 : 0);
                if (snoop_valid) begin
                    eval_snoop(s_cmd, s_addr);
                    if (exp_cmd == 3 && (s_cmd == 2 || s_cmd == 3) && s_addr == addr)
                        exp_cmd = 2; // R12 upgrade becomes read-for-ownership
                end
                if (cyc == delay) begin
                    m_tag[idx] = tg;
                    m_st[idx]  = (exp_cmd == 1) ? (shr ? SS : SE) : SM;
                end
                if (cyc != delay) begin
                    @(posedge clk);
                    #1 snoop_valid = 1'b0;
                end
            end
        end
        @(posedge clk);
        #1;
        cpu_req_valid = 1'b0;
        bus_grant     = 1'b0;
        snoop_valid   = 1'b0;
    endtask

    task automatic rd(input int addr, input bit shr);
        do_cpu(0, addr, 1, shr, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input int addr);
        do_cpu(1, addr, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'h1C0DE5));
        for (int i = 0; i < NL; i++) begin
            m_st[i]  = SI;
            m_tag[i] = 0;
        end
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset cpu_done", int'(cpu_done), 0);
        check("R1 reset wb_req", int'(wb_req), 0);
        check("R1 reset bus_req_valid", int'(bus_req_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing present after reset
        do_snoop(1, 5);
        // R2 exclusive fill, R4 silent write, R6 supply from M then O
        rd(5, 0);
        wr(5);
        do_snoop(1, 5);
        do_snoop(1, 5);
        rd(5, 0);            // R5 read hit on owned
        wr(5);               // R4 owned needs invalidate
        do_snoop(2, 5);      // R7 supply and drop
        // R2 shared fill, R6 no supply, R12 demotion on invalidate snoop
        rd(6, 1);
        do_snoop(1, 6);
        do_cpu(1, 6, 2, 0, 1, 3, 6, 0, 0, 0);
        do_snoop(1, 6);      // R6 modified supplies
        // R3 write miss, R10 dirty and clean victims
        wr(3);
        rd(7, 0);            // R10 evicts modified 3
        rd(11, 1);           // R10 evicts exclusive 7, no writeback
        do_snoop(1, 15);     // R9 tag mismatch
        do_snoop(0, 11);     // R9 command none
        do_snoop(3, 11);     // R8 drop, no supply
        // R11 snoop in the same cycle as a local access
        do_cpu(0, 6, 1, 0, 0, 0, 0, 1, 1, 6);
        do_cpu(1, 2, 1, 0, 0, 0, 0, 1, 2, 6);

        for (int n = 0; n < 3000; n++) begin
            int pick, dly;
            pick = int'($urandom % 10);
            if (pick < 3) begin
                do_snoop(int'($urandom % 4), int'($urandom % (1 << AW)));
            end else begin
                dly = int'($urandom % 4);
                do_cpu(bit'($urandom % 2), int'($urandom % (1 << AW)), dly,
                       bit'($urandom % 2), ($urandom % 3) == 0,
                       1 + int'($urandom % 3), int'($urandom % (1 << AW)),
                       ($urandom % 8) == 0, 1 + int'($urandom % 3),
                       int'($urandom % (1 << AW)));
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule